// File: doc/BRIEF.md
# Variable-Length Display Command Decoder

This block sits behind the byte receiver of a serial display port. Each accepted byte arrives with a one-cycle strobe and a select line. A high select marks pixel data, which goes straight out on the memory write path. A low select marks a command byte. The decoder treats the first command byte as an opcode. It looks up how many trailing argument bytes that opcode needs (zero to eight), collects them, and then raises a one-cycle update pulse. The pulse carries the opcode and the full argument bus.

Three opcodes change state held inside the block. One sets the column window, one sets the row window, and one sets the address remap byte. Every other known opcode produces only the update pulse, so logic further down the chip can use it. An opcode with no entry in the table is discarded at once and flagged. The all-ones byte is discarded without a flag.

Top module: `disp_cmd_decoder`

## Requirements
- R1: After a synchronous active-low reset the column window is 0 to COLS-1 (0..63), the row window is 0 to ROWS-1 (0..79) and the remap byte is 0x00. upd_valid, bad_opcode and mem_we are low.
- R2: A strobed byte with is_data high raises mem_we in the same cycle with mem_wdata equal to the byte. It causes no update pulse and no error. It leaves a partly collected command intact, so the next command byte continues that command.
- R3: Opcodes 0x84, 0x85, 0x86, 0xA4 through 0xA7, 0xAE, 0xAF and 0xE3 take no arguments. The opcode byte's own cycle shows upd_valid high, upd_opcode equal to the byte, and upd_args all zero.
- R4: Opcodes 0x81, 0xA0, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF take one argument. The pulse comes in the cycle of the argument byte, with the argument in upd_args[7:0] and the higher bits zero.
- R5: Opcode 0xB8 takes eight arguments. The pulse comes with the eighth argument byte, and argument k (counted from 0) appears in upd_args[8k+7:8k].
- R6: Opcode 0x15 takes two arguments. From the cycle after its pulse, col_start equals argument 0 modulo COLS and col_end equals argument 1 modulo COLS.
- R7: Opcode 0x75 takes two arguments. From the cycle after its pulse, row_start equals argument 0 modulo ROWS and row_end equals argument 1 modulo ROWS.
- R8: Opcode 0xA0 stores its argument as the remap byte from the cycle after its pulse. addr_vertical follows bit 2 of that byte.
- R9: An opcode byte not listed in R3 to R8 (other than 0xFF) raises bad_opcode for that cycle only. It gives no update pulse, changes no stored state, and the next command byte is taken as a new opcode.
- R10: The opcode byte 0xFF is dropped. It gives no pulse and no error, and the next command byte is taken as a new opcode.
- R11: While byte_valid is low, upd_valid, bad_opcode and mem_we stay low and no stored state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | One-cycle strobe marking a received byte |
| is_data | input | 1 | High: byte is pixel data; low: byte is a command |
| byte_in | input | 8 | Received byte |
| mem_we | output | 1 | Pixel data write strobe |
| mem_wdata | output | 8 | Pixel data byte |
| upd_valid | output | 1 | Command complete, one cycle |
| upd_opcode | output | 8 | Opcode of the completed command |
| upd_args | output | 64 | Arguments, argument k in bits 8k+7:8k, unused slots zero |
| bad_opcode | output | 1 | Unknown opcode was dropped this cycle |
| col_start | output | 6 | Column window start |
| col_end | output | 6 | Column window end |
| row_start | output | 7 | Row window start |
| row_end | output | 7 | Row window end |
| remap | output | 8 | Address remap byte |
| addr_vertical | output | 1 | Vertical address increment selected |

## Verification
A wrong byte count is the main internal fault. It shows at the ports on the next command byte: the pulse arrives a byte early or late, upd_opcode names an argument byte, or bad_opcode fires on a byte that was meant as an argument. Every later command then stays out of step until a run of unknown bytes happens to bring it back. A misplaced argument slot or a bad modulo shows on the argument bus in the pulse cycle, or on the window outputs one clock later. The bench therefore compares every output on every clock against a byte-level model, under both directed and random streams.

// File: rtl/dcd_pkg.sv
// Shared constants and types for the display command decoder.
// Assumes at most ARGS_MAX argument bytes per opcode.
package dcd_pkg;
    localparam int ARGS_MAX = 8;
    localparam int CNT_W    = $clog2(ARGS_MAX + 2);

    localparam logic [7:0] OP_COL_WIN = 8'h15;
    localparam logic [7:0] OP_ROW_WIN = 8'h75;
    localparam logic [7:0] OP_REMAP   = 8'hA0;
    localparam logic [7:0] OP_DROP    = 8'hFF;

    // Result of the per-opcode argument lookup.
    typedef struct packed {
        logic             known;  // opcode is in the table
        logic             drop;   // silently discarded opcode
        logic [CNT_W-1:0] nargs;  // trailing argument bytes
    } op_info_t;
endpackage

// File: rtl/dcd_arg_lut.sv
// Combinational opcode table: tells whether an opcode is known and how
// many argument bytes follow it. Assumes no opcode needs more than
// dcd_pkg::ARGS_MAX arguments.
module dcd_arg_lut
    import dcd_pkg::*;
(
    input  logic [7:0] opcode,
    output op_info_t   info
);
    // Decode the opcode into its argument count.
    always_comb begin
        info.known = 1'b1;
        info.drop  = 1'b0;
        info.nargs = '0;
        case (opcode)
            8'h84, 8'h85, 8'h86,
            8'hA4, 8'hA5, 8'hA6, 8'hA7,
            8'hAE, 8'hAF, 8'hE3:
                info.nargs = CNT_W'(0);
            8'h81, 8'hA0, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
            8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF:
                info.nargs = CNT_W'(1);
            OP_COL_WIN, OP_ROW_WIN:
                info.nargs = CNT_W'(2);
            8'hB8:
                info.nargs = CNT_W'(ARGS_MAX);
            OP_DROP: begin
                info.known = 1'b0;
                info.drop  = 1'b1;
            end
            default:
                info.known = 1'b0;
        endcase
    end
endmodule

// File: rtl/dcd_collector.sv
// Byte counter and argument store. Takes command bytes, finds the
// opcode's argument count and presents the finished command in the
// cycle of its last byte. Assumes the strobe is already qualified
// with command mode.
module dcd_collector
    import dcd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_strobe,
    input  logic [7:0]            byte_in,
    output logic                  upd_valid,
    output logic [7:0]            upd_opcode,
    output logic [ARGS_MAX*8-1:0] upd_args,
    output logic                  bad_opcode
);
    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       op_q;
    logic [7:0]       args_q [ARGS_MAX];
    logic [7:0]       cur_op;
    op_info_t         info;
    logic             at_opcode;
    logic             complete;
    logic [ARGS_MAX*8-1:0] merged;

    // Opcode under decode: the incoming byte when idle, else the held one.
    always_comb begin
        at_opcode = (cnt_q == '0);
        cur_op    = at_opcode ? byte_in : op_q;
    end

    dcd_arg_lut u_lut (
        .opcode (cur_op),
        .info   (info)
    );

    // Completion and error decode for the current byte.
    always_comb begin
        complete   = cmd_strobe && info.known && (cnt_q == info.nargs);
        bad_opcode = cmd_strobe && at_opcode && !info.known && !info.drop;
    end

    // Argument bus: stored slots with the incoming byte in its own slot.
    for (genvar k = 0; k < ARGS_MAX; k++) begin : g_slot
        always_comb begin
            if (!at_opcode && (int'(cnt_q) == k + 1))
                merged[k*8 +: 8] = byte_in;
            else
                merged[k*8 +: 8] = args_q[k];
        end
    end

    // Drive the update outputs; zero-argument opcodes carry an empty bus.
    always_comb begin
        upd_valid  = complete;
        upd_opcode = complete ? cur_op : 8'h00;
        upd_args   = (complete && !at_opcode) ? merged : '0;
    end

    // Byte counter: opens on an opcode with arguments, closes on the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            op_q  <= 8'h00;
        end else if (cmd_strobe) begin
            if (at_opcode) begin
                if (info.known && info.nargs != '0) begin
                    cnt_q <= CNT_W'(1);
                    op_q  <= byte_in;
                end
            end else if (complete) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // Argument store: cleared when a new command opens, filled per byte.
    for (genvar k = 0; k < ARGS_MAX; k++) begin : g_store
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                args_q[k] <= 8'h00;
            end else if (cmd_strobe) begin
                if (at_opcode)
                    args_q[k] <= 8'h00;
                else if (int'(cnt_q) == k + 1)
                    args_q[k] <= byte_in;
            end
        end
    end
endmodule

// File: rtl/dcd_window_regs.sv
// Holds the column window, row window and remap byte, loaded from the
// update pulse of their opcodes. Window bounds are reduced modulo the
// panel size. Assumes the pulse lasts exactly one cycle.
module dcd_window_regs
    import dcd_pkg::*;
#(
    parameter int COLS  = 64,
    parameter int ROWS  = 80,
    localparam int COL_W = $clog2(COLS),
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_valid,
    input  logic [7:0]       upd_opcode,
    input  logic [7:0]       arg0,
    input  logic [7:0]       arg1,
    output logic [COL_W-1:0] col_start,
    output logic [COL_W-1:0] col_end,
    output logic [ROW_W-1:0] row_start,
    output logic [ROW_W-1:0] row_end,
    output logic [7:0]       remap
);
    logic [COL_W-1:0] c0, c1;
    logic [ROW_W-1:0] r0, r1;

    // Reduce the raw arguments to in-range addresses.
    always_comb begin
        c0 = COL_W'(32'(arg0) % COLS);
        c1 = COL_W'(32'(arg1) % COLS);
        r0 = ROW_W'(32'(arg0) % ROWS);
        r1 = ROW_W'(32'(arg1) % ROWS);
    end

    // Load the selected register on its opcode's pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_start <= '0;
            col_end   <= COL_W'(COLS - 1);
            row_start <= '0;
            row_end   <= ROW_W'(ROWS - 1);
            remap     <= 8'h00;
        end else if (upd_valid) begin
            if (upd_opcode == OP_COL_WIN) begin
                col_start <= c0;
                col_end   <= c1;
            end
            if (upd_opcode == OP_ROW_WIN) begin
                row_start <= r0;
                row_end   <= r1;
            end
            if (upd_opcode == OP_REMAP)
                remap <= arg0;
        end
    end
endmodule

// File: rtl/disp_cmd_decoder.sv
// Top of the display command decoder. Splits strobed bytes by the
// command/data select: data goes to the memory write path, commands to
// the collector, whose pulse loads the window and remap registers.
// Assumes byte_valid is a single-cycle strobe per received byte.
module disp_cmd_decoder
    import dcd_pkg::*;
#(
    parameter int COLS = 64,
    parameter int ROWS = 80
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     byte_valid,
    input  logic                     is_data,
    input  logic [7:0]               byte_in,
    output logic                     mem_we,
    output logic [7:0]               mem_wdata,
    output logic                     upd_valid,
    output logic [7:0]               upd_opcode,
    output logic [ARGS_MAX*8-1:0]    upd_args,
    output logic                     bad_opcode,
    output logic [$clog2(COLS)-1:0]  col_start,
    output logic [$clog2(COLS)-1:0]  col_end,
    output logic [$clog2(ROWS)-1:0]  row_start,
    output logic [$clog2(ROWS)-1:0]  row_end,
    output logic [7:0]               remap,
    output logic                     addr_vertical
);
    localparam int VERT_BIT = 2;

    logic cmd_strobe;

    // Route the byte by the select line.
    always_comb begin
        cmd_strobe    = byte_valid && !is_data;
        mem_we        = byte_valid && is_data;
        mem_wdata     = byte_in;
        addr_vertical = remap[VERT_BIT];
    end

    dcd_collector u_coll (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_strobe (cmd_strobe),
        .byte_in    (byte_in),
        .upd_valid  (upd_valid),
        .upd_opcode (upd_opcode),
        .upd_args   (upd_args),
        .bad_opcode (bad_opcode)
    );

    dcd_window_regs #(
        .COLS (COLS),
        .ROWS (ROWS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_valid  (upd_valid),
        .upd_opcode (upd_opcode),
        .arg0       (upd_args[7:0]),
        .arg1       (upd_args[15:8]),
        .col_start  (col_start),
        .col_end    (col_end),
        .row_start  (row_start),
        .row_end    (row_end),
        .remap      (remap)
    );
endmodule

// File: rtl/dcd_checker.sv
// Protocol checks for the display command decoder, bound to the top.
module dcd_checker #(
    parameter int COLS = 64,
    parameter int ROWS = 80,
    localparam int COL_W = $clog2(COLS),
    localparam int ROW_W = $clog2(ROWS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_valid,
    input logic             mem_we,
    input logic             upd_valid,
    input logic [7:0]       upd_opcode,
    input logic [7:0]       arg0,
    input logic             bad_opcode,
    input logic [COL_W-1:0] col_start,
    input logic [ROW_W-1:0] row_start,
    input logic [ROW_W-1:0] row_end,
    input logic [7:0]       remap
);
    // R2: a data byte never completes or rejects a command
    a_r2_data_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (!upd_valid && !bad_opcode));

    // R9: a rejected opcode leaves stored state untouched
    a_r9_bad_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        bad_opcode |=> ($stable(col_start) && $stable(row_start) && $stable(remap)));

    // R9: rejection and completion are exclusive
    a_r9_bad_not_upd: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bad_opcode, upd_valid}));

    // R6: column start follows its argument one cycle after the pulse
    a_r6_col_load: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_opcode == 8'h15) |=>
            (col_start == COL_W'(32'($past(arg0)) % COLS)));

    // R7: row window always within the panel
    a_r7_row_range: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(row_start) < ROWS) && (32'(row_end) < ROWS));

    // R8: remap only moves after an update pulse
    a_r8_remap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(remap));

    // R11: no strobe, no output activity
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |-> (!upd_valid && !bad_opcode && !mem_we));
endmodule

bind disp_cmd_decoder dcd_checker #(
    .COLS (COLS),
    .ROWS (ROWS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .mem_we     (mem_we),
    .upd_valid  (upd_valid),
    .upd_opcode (upd_opcode),
    .arg0       (upd_args[7:0]),
    .bad_opcode (bad_opcode),
    .col_start  (col_start),
    .row_start  (row_start),
    .row_end    (row_end),
    .remap      (remap)
);

// File: tb/disp_cmd_decoder_tb.sv
// Bench: behavioural byte-level model compared against the block every clock.
module disp_cmd_decoder_tb;
    localparam int COLS = 64;
    localparam int ROWS = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic        is_data = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        mem_we, upd_valid, bad_opcode, addr_vertical;
    logic [7:0]  mem_wdata, upd_opcode, remap;
    logic [63:0] upd_args;
    logic [5:0]  col_start, col_end;
    logic [6:0]  row_start, row_end;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    disp_cmd_decoder #(.COLS(COLS), .ROWS(ROWS)) u_dut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .is_data(is_data),
        .byte_in(byte_in), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .upd_valid(upd_valid), .upd_opcode(upd_opcode), .upd_args(upd_args),
        .bad_opcode(bad_opcode), .col_start(col_start), .col_end(col_end),
        .row_start(row_start), .row_end(row_end), .remap(remap),
        .addr_vertical(addr_vertical)
    );

    // Model state
    int         m_cnt = 0;
    logic [7:0] m_op = 8'h00;
    logic [7:0] m_args[$];
    int m_cs = 0, m_ce = COLS - 1, m_rs = 0, m_re = ROWS - 1;
    logic [7:0] m_remap = 8'h00;

    // Argument count per opcode: -1 unknown, -2 silently dropped.
    function automatic int need(input logic [7:0] op);
        if (op == 8'hFF) return -2;
        if (op inside {8'hE3, 8'hAE, 8'hAF, [8'hA4:8'hA7], [8'h84:8'h86]}) return 0;
        if (op inside {8'h15, 8'h75}) return 2;
        if (op == 8'hB8) return 8;
        if (op inside {8'h81, 8'hA0, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
                       8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF}) return 1;
        return -1;
    endfunction

    function automatic string tag_of(input logic [7:0] op);
        if (op == 8'h15) return "R6";
        if (op == 8'h75) return "R7";
        if (op == 8'hA0) return "R8";
        if (op == 8'hB8) return "R5";
        if (need(op) == 0) return "R3";
        return "R4";
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, compare before the rising edge,
    // then advance the model.
    task automatic step(input bit v, input bit d, input logic [7:0] b);
        bit         e_upd = 0, e_bad = 0;
        logic [7:0] e_op = 8'h00;
        logic [63:0] e_args = '0;
        string      t = "R11";
        int         n;
        logic [7:0] done_args[$];
        @(negedge clk);
        byte_valid = v; is_data = d; byte_in = b;
        #4;
        if (v && d) t = "R2";
        if (v && !d) begin
            if (m_cnt == 0) begin
                n = need(b);
                t = (n == -2) ? "R10" : (n == -1) ? "R9" : tag_of(b);
                if (n == -1) e_bad = 1;
                if (n == 0) begin e_upd = 1; e_op = b; end
            end else begin
                t = tag_of(m_op);
                if (m_args.size() + 1 == need(m_op)) begin
                    e_upd = 1; e_op = m_op;
                    done_args = m_args;
                    done_args.push_back(b);
                    foreach (done_args[k]) e_args[k*8 +: 8] = done_args[k];
                end
            end
        end
        // Registered state reflects earlier commands only.
        chk(col_start == 6'(m_cs) && col_end == 6'(m_ce), "R6", "col window",
            {col_start, col_end}, {6'(m_cs), 6'(m_ce)});
        chk(row_start == 7'(m_rs) && row_end == 7'(m_re), "R7", "row window",
            {row_start, row_end}, {7'(m_rs), 7'(m_re)});
        chk(remap == m_remap && addr_vertical == m_remap[2], "R8", "remap",
            {addr_vertical, remap}, {m_remap[2], m_remap});
        chk(mem_we == (v && d) && (!(v && d) || mem_wdata == b), "R2", "data path",
            {mem_we, mem_wdata}, {(v && d), b});
        chk(upd_valid == e_upd, t, "upd_valid", 64'(upd_valid), 64'(e_upd));
        if (e_upd) begin
            chk(upd_opcode == e_op, t, "upd_opcode", 64'(upd_opcode), 64'(e_op));
            chk(upd_args == e_args, t, "upd_args", upd_args, e_args);
        end
        chk(bad_opcode == e_bad, (t == "R10") ? "R10" : "R9", "bad_opcode",
            64'(bad_opcode), 64'(e_bad));
        // Advance the model.
        if (v && !d) begin
            if (m_cnt == 0) begin
                n = need(b);
                if (n > 0) begin m_op = b; m_args.delete(); m_cnt = 1; end
            end else begin
                m_args.push_back(b);
                if (m_args.size() == need(m_op)) m_cnt = 0;
            end
        end
        if (e_upd) begin
            if (e_op == 8'h15) begin m_cs = int'(e_args[7:0]) % COLS; m_ce = int'(e_args[15:8]) % COLS; end
            if (e_op == 8'h75) begin m_rs = int'(e_args[7:0]) % ROWS; m_re = int'(e_args[15:8]) % ROWS; end
            if (e_op == 8'hA0) m_remap = e_args[7:0];
        end
    endtask

    task automatic cmd(input logic [7:0] b); step(1, 0, b); endtask

    logic [7:0] pool [16] = '{8'h15, 8'h75, 8'hA0, 8'hB8, 8'h81, 8'hAF, 8'hE3, 8'hFF,
                              8'h00, 8'h42, 8'hA4, 8'hBF, 8'h86, 8'hA2, 8'hC0, 8'h75};

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        #4;
        chk(col_start == 0 && col_end == 6'(COLS - 1), "R1", "reset col",
            {col_start, col_end}, {6'd0, 6'(COLS - 1)});
        chk(row_start == 0 && row_end == 7'(ROWS - 1), "R1", "reset row",
            {row_start, row_end}, {7'd0, 7'(ROWS - 1)});
        chk(remap == 0 && !upd_valid && !bad_opcode && !mem_we, "R1", "reset outputs",
            {remap, upd_valid, bad_opcode, mem_we}, 64'd0);
        // R11: idle
        repeat (3) step(0, 0, 8'h15);
        // R3: zero-argument opcodes
        cmd(8'hA4); cmd(8'hAF); cmd(8'hE3); cmd(8'h85);
        // R4: one-argument opcode
        cmd(8'h81); cmd(8'h7F);
        // R6: column window with wrap
        cmd(8'h15); cmd(8'd70); cmd(8'd10); step(0, 0, 0);
        // R7: row window modulo 80
        cmd(8'h75); cmd(8'd85); cmd(8'd200); step(0, 0, 0);
        // R8: remap vertical bit
        cmd(8'hA0); cmd(8'h04); step(0, 0, 0);
        // R5: eight arguments
        cmd(8'hB8);
        for (int k = 1; k <= 8; k++) cmd(8'(k * 17));
        // R9: unknown opcodes, then a normal command
        cmd(8'h00); cmd(8'h42); cmd(8'hA0); cmd(8'h00);
        // R10: drop byte then zero-arg opcode
        cmd(8'hFF); cmd(8'hAE);
        // R2: data interleaved inside a command
        cmd(8'h15); step(1, 1, 8'h5A); cmd(8'd3); step(1, 1, 8'hC3); step(0, 0, 0); cmd(8'd40);
        step(1, 1, 8'h11);
        // Random stream
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 9);
            if (r < 2)      step(0, 0, 8'($urandom));
            else if (r < 4) step(1, 1, 8'($urandom));
            else if (r < 7) cmd(pool[$urandom_range(0, 15)]);
            else            cmd(8'($urandom));
        end
        step(0, 0, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule